// File: doc/BRIEF.md
# Halfword Packing Word Stuffer

This block sits on the link side of a transmit path, in the same clock domain as the serial link layer. A clock-crossing buffer upstream delivers it 32-bit words that may be only partly filled. Host buffers can begin on any even byte address, so each 16-bit half of an input word has its own valid bit. The block squeezes out the gaps and passes on only fully populated 32-bit words, in which the two halves keep their stream order.

A single halfword holding register keeps a lone half until its partner arrives, including a partner that arrives in a later input beat. One output register, with a valid/ready handshake, applies backpressure to the input. At the end of a transfer a flush request pushes out a leftover half as a marked partial word.

Top module: `hws_stuffer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `out_valid` is 0 and no half is held. A flush straight after reset therefore produces no output.
- R2: An accepted input with `in_mask` = 2'b11 and no held half puts `{in_data[31:16], in_data[15:0]}` on `out_data` on the next clock edge. Mask bit 0 marks bits [15:0] as valid and mask bit 1 marks bits [31:16]. The lower half comes first in stream order.
- R3: Two single valid halves, from the same or from separate accepted beats, are merged with the earlier half in `out_data[15:0]` and the later half in `out_data[31:16]`.
- R4: An accepted input with mask 2'b11 while a half is held emits `{in_data[15:0], held}` and keeps `in_data[31:16]` as the new held half.
- R5: An accepted input with mask 2'b00 produces no output and leaves the held half unchanged.
- R6: When `flush` is high and a half is held, the block emits `{16'h0000, held}` with `out_partial` = 1 once the output register is free, and the held half is then cleared. While `flush` is high, `in_ready` is 0. When `flush` is high and nothing is held, nothing is emitted.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_data` and `out_partial` stay unchanged. In that state `in_ready` is 0 exactly when the presented input would complete a word. It is 1 otherwise, unless `flush` is high.
- R8: The halves that leave the block are exactly the valid input halves, in order, with none lost and none duplicated.
- R9: Every word that is not a flushed partial word carries `out_partial` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 32 | Input word: two 16-bit halves |
| in_mask | input | 2 | Per-half valid bits (bit 0 is the lower half) |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken at the clock edge |
| flush | input | 1 | Push out a held half as a partial word |
| out_data | output | 32 | Packed output word |
| out_partial | output | 1 | Output word holds one half only, in bits [15:0] |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |

## Verification
Each packed or flushed word appears on `out_data` one clock edge after the input handshake or flush that completes it. `in_ready` is a combinational result of the inputs presented in the same cycle. The bench drives inputs just after the falling edge, reads `in_ready` and both handshakes two nanoseconds later, and checks the registered outputs after the following falling edge, one edge downstream. A queue of expected halves, filled at every input handshake and drained at every output handshake, checks stream order across random masks, stalls and flushes.

// File: rtl/hws_pkg.sv
// Shared definitions for the halfword packing stuffer.
// Assumes an output word is exactly two halves wide.
package hws_pkg;
    localparam int LANES = 2;

    // What an accepted beat does to the holding register and the output.
    typedef enum logic [1:0] {
        ACT_NONE      = 2'd0,
        ACT_HOLD      = 2'd1,
        ACT_EMIT      = 2'd2,
        ACT_EMIT_HOLD = 2'd3
    } beat_act_t;
endpackage

// File: rtl/hws_merge.sv
// Combinational merge: works out, for the presented beat, the packed word
// and the next holding-register contents. It does not look at handshakes;
// the top applies the result only when the beat is accepted.
module hws_merge #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              hold_valid,
    input  logic [HALF_W-1:0] hold_data,
    input  logic [WORD_W-1:0] beat_data,
    input  logic [1:0]        beat_mask,
    output hws_pkg::beat_act_t act,
    output logic              beat_emits,
    output logic [WORD_W-1:0] word,
    output logic              next_hold_valid,
    output logic [HALF_W-1:0] next_hold_data
);
    import hws_pkg::*;

    logic [HALF_W-1:0] lane [LANES];

    // Split the beat into its two halves.
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane[g] = beat_data[g*HALF_W +: HALF_W];
        end
    endgenerate

    // Decide the packing action from held state and mask.
    always_comb begin
        act             = ACT_NONE;
        word            = '0;
        next_hold_valid = hold_valid;
        next_hold_data  = hold_data;
        unique case ({hold_valid, beat_mask})
            3'b0_01: begin act = ACT_HOLD; next_hold_valid = 1'b1; next_hold_data = lane[0]; end
            3'b0_10: begin act = ACT_HOLD; next_hold_valid = 1'b1; next_hold_data = lane[1]; end
            3'b0_11: begin act = ACT_EMIT; word = {lane[1], lane[0]}; end
            3'b1_01: begin act = ACT_EMIT; word = {lane[0], hold_data}; next_hold_valid = 1'b0; end
            3'b1_10: begin act = ACT_EMIT; word = {lane[1], hold_data}; next_hold_valid = 1'b0; end
            3'b1_11: begin
                act = ACT_EMIT_HOLD;
                word = {lane[0], hold_data};
                next_hold_data = lane[1];
            end
            default: act = ACT_NONE;
        endcase
    end

    assign beat_emits = (act == ACT_EMIT) || (act == ACT_EMIT_HOLD);
endmodule

// File: rtl/hws_hold.sv
// One-halfword holding register for a leftover half awaiting a partner.
// Load takes priority over clear; both are single-cycle strobes.
module hws_hold #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_valid,
    input  logic [HALF_W-1:0] load_data,
    input  logic              clear,
    output logic              hold_valid,
    output logic [HALF_W-1:0] hold_data
);
    // Update held half on accepted beats and flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (load) begin
            hold_valid <= load_valid;
            hold_data  <= load_data;
        end else if (clear) begin
            hold_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/hws_outreg.sv
// Single output register with valid/ready. Reports whether a new word can
// be written this cycle (empty, or current word being taken).
module hws_outreg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              load_partial,
    input  logic              out_ready,
    output logic              slot_free,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_partial
);
    assign slot_free = !out_valid || out_ready;

    // Hold the word until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_partial <= 1'b0;
        end else if (load) begin
            out_valid   <= 1'b1;
            out_data    <= load_data;
            out_partial <= load_partial;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/hws_stuffer.sv
// Halfword packing stuffer: turns sparse 32-bit words with per-half valid
// bits into dense 32-bit words. Single clock domain, synchronous active-low
// reset. Assumes the lower half of an input precedes its upper half.
module hws_stuffer #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic [1:0]        in_mask,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              flush,
    output logic [WORD_W-1:0] out_data,
    output logic              out_partial,
    output logic              out_valid,
    input  logic              out_ready
);
    import hws_pkg::*;

    logic              hold_valid;
    logic [HALF_W-1:0] hold_data;
    beat_act_t         act;
    logic              beat_emits;
    logic [WORD_W-1:0] beat_word;
    logic              nxt_hold_valid;
    logic [HALF_W-1:0] nxt_hold_data;
    logic              slot_free;
    logic              accept;
    logic              flush_go;
    logic              out_load;
    logic [WORD_W-1:0] out_word;

    hws_merge #(.HALF_W(HALF_W)) u_merge (
        .hold_valid      (hold_valid),
        .hold_data       (hold_data),
        .beat_data       (in_data),
        .beat_mask       (in_mask),
        .act             (act),
        .beat_emits      (beat_emits),
        .word            (beat_word),
        .next_hold_valid (nxt_hold_valid),
        .next_hold_data  (nxt_hold_data)
    );

    // Flush stalls the input; otherwise stall only if a word cannot be placed.
    assign in_ready = !flush && (!beat_emits || slot_free);
    assign accept   = in_valid && in_ready;
    assign flush_go = flush && hold_valid && slot_free;
    assign out_load = (accept && beat_emits) || flush_go;
    assign out_word = flush_go ? {{HALF_W{1'b0}}, hold_data} : beat_word;

    hws_hold #(.HALF_W(HALF_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_valid (nxt_hold_valid),
        .load_data  (nxt_hold_data),
        .clear      (flush_go),
        .hold_valid (hold_valid),
        .hold_data  (hold_data)
    );

    hws_outreg #(.WORD_W(WORD_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (out_load),
        .load_data    (out_word),
        .load_partial (flush_go),
        .out_ready    (out_ready),
        .slot_free    (slot_free),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_partial  (out_partial)
    );
endmodule

// File: rtl/hws_stuffer_chk.sv
// Port-level checker for hws_stuffer, attached by bind below.
module hws_stuffer_chk #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              flush,
    input logic [WORD_W-1:0] out_data,
    input logic              out_partial,
    input logic              out_valid,
    input logic              out_ready
);
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_partial_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_partial) |-> (out_data[WORD_W-1:HALF_W] == '0));

    assert_flush_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_partial)));

    assert_word_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(in_valid && in_ready) || $past(flush)));
endmodule

bind hws_stuffer hws_stuffer_chk #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .flush       (flush),
    .out_data    (out_data),
    .out_partial (out_partial),
    .out_valid   (out_valid),
    .out_ready   (out_ready)
);

// File: tb/hws_stuffer_tb.sv
module hws_stuffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_mask = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        flush = 1'b0;
    logic [31:0] out_data;
    logic        out_partial;
    logic        out_valid;
    logic        out_ready = 1'b1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [15:0] expq[$];
    logic last_in_ready;

    always #4 clk = ~clk;

    hws_stuffer u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_mask(in_mask),
        .in_valid(in_valid), .in_ready(in_ready), .flush(flush),
        .out_data(out_data), .out_partial(out_partial), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected output word built from the reference queue.
    function automatic logic [32:0] pop_word(input bit partial);
        logic [15:0] a, b;
        a = expq.pop_front();
        if (partial) return {1'b1, 16'h0000, a};
        b = expq.pop_front();
        return {1'b0, b, a};
    endfunction

    // One cycle: drive after negedge, observe handshakes, score them.
    task automatic step(input bit v, input logic [1:0] m, input logic [31:0] d,
                        input bit f, input bit ordy);
        bit in_hs, out_hs;
        in_valid = v; in_mask = m; in_data = d; flush = f; out_ready = ordy;
        #2;
        last_in_ready = in_ready;
        in_hs  = in_valid && in_ready;
        out_hs = out_valid && out_ready;
        if (out_hs) begin
            if (expq.size() < (out_partial ? 1 : 2)) begin
                check("R8 extra word", {out_partial, out_data}, 33'h0);
            end else begin
                check("R8 stream order", {out_partial, out_data}, pop_word(out_partial));
            end
        end
        if (in_hs) begin
            if (m[0]) expq.push_back(d[15:0]);
            if (m[1]) expq.push_back(d[31:16]);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk);
        check("R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);
        step(0, 2'b00, 0, 1, 1);
        check("R1 flush after reset empty", out_valid, 0);

        step(1, 2'b11, 32'hBBBB_AAAA, 0, 1);
        check("R2 full word", {out_valid, out_partial, out_data}, {2'b10, 32'hBBBB_AAAA});
        check("R9 full not partial", out_partial, 0);

        step(1, 2'b01, 32'hFFFF_1111, 0, 1);
        check("R3 single half no word", out_valid, 0);
        step(1, 2'b00, 32'hDEAD_BEEF, 0, 1);
        check("R5 empty beat no word", out_valid, 0);
        step(1, 2'b10, 32'h2222_EEEE, 0, 1);
        check("R3 merged order / R5 hold kept", {out_valid, out_data}, {1'b1, 32'h2222_1111});

        step(1, 2'b10, 32'h3333_0000, 0, 1);
        step(1, 2'b11, 32'h5555_4444, 0, 1);
        check("R4 held plus full", {out_valid, out_data}, {1'b1, 32'h4444_3333});
        step(1, 2'b11, 32'h7777_6666, 1, 1);
        check("R6 flush stalls input", last_in_ready, 0);
        check("R6 partial word", {out_valid, out_partial, out_data}, {2'b11, 32'h0000_5555});
        step(0, 2'b00, 0, 1, 1);
        check("R6 flush nothing held", out_valid, 0);

        // Backpressure
        step(1, 2'b11, 32'h9999_8888, 0, 0);
        step(1, 2'b11, 32'hAAAA_0001, 0, 0);
        check("R7 ready low when word blocked", last_in_ready, 0);
        check("R7 word stable", {out_valid, out_data}, {1'b1, 32'h9999_8888});
        step(1, 2'b01, 32'h0000_0002, 0, 0);
        check("R7 ready high for hold-only beat", last_in_ready, 1);
        check("R7 word stable again", out_data, 32'h9999_8888);
        step(1, 2'b10, 32'h0003_0000, 0, 1);
        check("R7 ready when slot frees", last_in_ready, 1);
        check("R3 after stall", {out_valid, out_data}, {1'b1, 32'h0003_0002});

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, 2'($urandom), $urandom,
                 ($urandom % 20) == 0, ($urandom % 10) < 7);
        end
        // Drain
        for (int i = 0; i < 6; i++) step(0, 2'b00, 0, 1, 1);
        check("R8 all halves delivered", expq.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule